// File: doc/BRIEF.md
# SMBus SCL Bus-Free and Stuck-Low Timeout Monitor

This block sits beside a two-wire SMBus master controller and watches the SCL line. It keeps two timers, both advanced by a prescaled tick so that long real-time windows can be reached at the system clock rate. The first timer measures how long SCL has stayed high without a break. When it overflows, the bus counts as idle and a one-cycle free-timeout strobe is raised. If a START request is pending at that moment, a one-cycle start-permitted strobe is raised with it.

The second timer measures how long SCL has been held low. When it overflows, it sets a sticky interrupt flag so that the controller can reset its bus interface. Software clears that flag with a write-one-to-clear pulse. Each timer begins counting from its own programmable reload value. A timer therefore overflows after 2^WIDTH minus its reload value ticks, which lets the bus-free window be set below 50 us and the stuck-low window near 25 ms.

Top module: `smb_timeout_mon`

## Requirements
- R1: When `free_en` is 0, the bus-free timer is held at `free_reload` and `free_tmo` stays 0.
- R2: While the synchronized SCL is high and `free_en` is 1, the bus-free timer advances by one on each cycle with `tick`=1, starting from `free_reload`. It overflows on the tick taken when its value is all ones.
- R3: `free_tmo` is high for exactly the one cycle after the overflow tick. With `tick`=1 every cycle and SCL rising at the input, it first appears on rising edge number 258-R after the change (WIDTH=8, reload R ≤ 0xFE).
- R4: The bus-free timer reloads `free_reload` in every cycle where the synchronized SCL is low, so only an unbroken high period is measured.
- R5: A `start_req` pulse makes a START pending. At the next bus-free overflow, `start_ok` is high in the same cycle as `free_tmo`, and the pending request is then dropped. A later overflow with no new request leaves `start_ok` at 0.
- R6: When `low_en` is 0, the SCL-low timer is held at `low_reload` and `low_irq` never sets.
- R7: While the synchronized SCL is low and `low_en` is 1, the SCL-low timer counts ticks upward from `low_reload`. While SCL is high, it is forced to `low_reload`. Its overflow sets `low_irq` on edge 258-R after SCL falls at the input (WIDTH=8, tick every cycle).
- R8: `low_irq` stays set until a `low_clr` pulse. It then reads 0 on the edge after the pulse, unless a new overflow occurs in that same cycle, in which case the set wins.
- R9: Synchronous `rst` clears both timers, both strobes and `low_irq`, and drops a pending START.
- R10: With `tick` held at 0, neither timer changes value, so no timeout occurs however long SCL stays in one state.
- R11: SCL passes through a two-flop synchronizer before either timer sees it. The synchronizer resets to 1, the idle bus level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Prescaled timer advance enable |
| scl_in | input | 1 | Raw SCL line level (asynchronous) |
| free_en | input | 1 | Bus-free timer enable |
| low_en | input | 1 | SCL-low timeout enable |
| free_reload | input | WIDTH | Bus-free timer start value |
| low_reload | input | WIDTH | SCL-low timer start value |
| start_req | input | 1 | Pulse that makes a START pending |
| low_clr | input | 1 | Write-one-to-clear pulse for `low_irq` |
| start_ok | output | 1 | One-cycle START permission strobe |
| free_tmo | output | 1 | One-cycle bus-free overflow strobe |
| low_irq | output | 1 | Sticky SCL-low timeout flag |

## Verification
The bench sweeps both reload values across the 8-bit range. For each one it measures the exact edge on which each indication appears. A miscounted synchronizer depth or an overflow decoded one value early shows up as a result that is off by one cycle. A broken high period is inserted before a measurement: a timer that failed to reload on low SCL would then fire early. START handling is checked on two later overflows, one with a request and one without. Failing to drop the request would give a second grant, and a reset that kept the request would give a grant nobody asked for. The bench also holds `tick` low, pulses the clear for the sticky flag, and confirms the flag is not cleared by SCL going high alone.

// File: rtl/smb_timeout_mon.sv
module smb_timeout_mon #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             scl_in,
  input  logic             free_en,
  input  logic             low_en,
  input  logic [WIDTH-1:0] free_reload,
  input  logic [WIDTH-1:0] low_reload,
  input  logic             start_req,
  input  logic             low_clr,
  output logic             start_ok,
  output logic             free_tmo,
  output logic             low_irq
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic             scl_m, scl_s;
  logic [WIDTH-1:0] free_cnt, low_cnt;
  logic             pend;
  logic             free_ovf, low_ovf;

  // two-flop synchronizer, idle level high
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m <= 1'b1;
      scl_s <= 1'b1;
    end else begin
      scl_m <= scl_in;
      scl_s <= scl_m;
    end
  end

  assign free_ovf = free_en &  scl_s & tick & (free_cnt == TOP);
  assign low_ovf  = low_en  & ~scl_s & tick & (low_cnt  == TOP);

  always_ff @(posedge clk) begin
    if (rst)                   free_cnt <= '0;
    else if (!free_en || !scl_s) free_cnt <= free_reload;
    else if (free_ovf)         free_cnt <= free_reload;
    else if (tick)             free_cnt <= free_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                   low_cnt <= '0;
    else if (!low_en || scl_s) low_cnt <= low_reload;
    else if (low_ovf)          low_cnt <= low_reload;
    else if (tick)             low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      free_tmo <= 1'b0;
      start_ok <= 1'b0;
      low_irq  <= 1'b0;
    end else begin
      pend     <= free_ovf ? 1'b0 : (pend | start_req);
      free_tmo <= free_ovf;
      start_ok <= free_ovf & (pend | start_req);
      if (low_ovf)      low_irq <= 1'b1;
      else if (low_clr) low_irq <= 1'b0;
    end
  end

  // R1
  free_off_chk: assert property (@(posedge clk) disable iff (rst)
    !free_en |=> !free_tmo);
  // R4
  free_high_chk: assert property (@(posedge clk) disable iff (rst)
    free_tmo |-> $past(scl_s));
  // R5
  start_pair_chk: assert property (@(posedge clk) disable iff (rst)
    start_ok |-> free_tmo);
  // R6
  low_off_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(low_irq) |-> $past(low_en && !scl_s));
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (low_irq && !low_clr) |=> low_irq);
  // R10
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && scl_s && free_en && $past(scl_s)) |=> $stable(free_cnt));
endmodule

// File: tb/smb_timeout_mon_tb.sv
module smb_timeout_mon_tb_top;
  localparam int CLK_P = 10;
  localparam int W = 8;

  logic clk = 0, rst = 1, tick = 1, scl_in = 1, free_en = 0, low_en = 0;
  logic [W-1:0] free_reload = '0, low_reload = '0;
  logic start_req = 0, low_clr = 0;
  logic start_ok, free_tmo, low_irq;
  int checks = 0, errs = 0, cyc = 0;

  smb_timeout_mon #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .scl_in(scl_in), .free_en(free_en),
    .low_en(low_en), .free_reload(free_reload), .low_reload(low_reload),
    .start_req(start_req), .low_clr(low_clr), .start_ok(start_ok),
    .free_tmo(free_tmo), .low_irq(low_irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errs++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // first edge on which free_tmo is high; start_ok sampled there; next cycle free_tmo
  task automatic meas_free(input int limit, output int n, output int st, output int nxt);
    n = 0; st = 0; nxt = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #1;
      if (free_tmo) begin n = i; st = start_ok; break; end
    end
    @(posedge clk); #1;
    nxt = free_tmo;
    @(negedge clk);
  endtask

  task automatic meas_irq(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #1;
      if (low_irq) begin n = i; break; end
    end
    @(negedge clk);
  endtask

  initial begin
    int n, st, nxt;
    int rl [5] = '{254, 240, 192, 128, 0};
    wait_cyc(3);
    chk("R9 reset free_tmo", free_tmo, 0);
    chk("R9 reset start_ok", start_ok, 0);
    chk("R9 reset low_irq", low_irq, 0);
    rst = 0;

    // R1: disabled bus-free timer
    scl_in = 1; free_reload = 8'hFE;
    meas_free(300, n, st, nxt);
    chk("R1 no strobe when disabled", n, 0);

    // R2/R3/R11 sweep
    free_en = 1;
    foreach (rl[k]) begin
      scl_in = 0; free_reload = rl[k][W-1:0];
      wait_cyc(4);
      scl_in = 1;
      meas_free(400, n, st, nxt);
      chk($sformatf("R3 R11 free delay R=%0d", rl[k]), n, 258 - rl[k]);
      chk($sformatf("R3 single-cycle strobe R=%0d", rl[k]), nxt, 0);
    end

    // R4: broken high period
    scl_in = 0; free_reload = 8'hC0; wait_cyc(4);
    scl_in = 1; wait_cyc(30);
    scl_in = 0; wait_cyc(5);
    scl_in = 1;
    meas_free(200, n, st, nxt);
    chk("R4 reload on low", n, 66);

    // R5: pending START granted once
    scl_in = 0; free_reload = 8'hF0; wait_cyc(4);
    start_req = 1; wait_cyc(1); start_req = 0; wait_cyc(2);
    scl_in = 1;
    meas_free(100, n, st, nxt);
    chk("R5 grant timing", n, 18);
    chk("R5 start_ok with free_tmo", st, 1);
    meas_free(100, n, st, nxt);
    chk("R5 next overflow present", (n > 0) ? 1 : 0, 1);
    chk("R5 no second grant", st, 0);

    // R9: reset drops pending START
    scl_in = 0; wait_cyc(3);
    start_req = 1; wait_cyc(1); start_req = 0;
    rst = 1; wait_cyc(2); rst = 0; wait_cyc(4);
    scl_in = 1;
    meas_free(100, n, st, nxt);
    chk("R9 overflow after reset", n, 18);
    chk("R9 pending dropped", st, 0);

    // R10: tick held low
    scl_in = 1; free_reload = 8'hFE;
    scl_in = 0; wait_cyc(4); tick = 0; scl_in = 1;
    meas_free(200, n, st, nxt);
    chk("R10 no strobe without tick", n, 0);
    tick = 1;
    meas_free(20, n, st, nxt);
    chk("R10 resume from held value", n, 2);
    free_en = 0;

    // R6: low timer disabled
    scl_in = 0;
    meas_irq(300, n);
    chk("R6 no irq when disabled", n, 0);

    // R7/R8 sweep
    low_en = 1;
    foreach (rl[k]) begin
      scl_in = 1; low_reload = rl[k][W-1:0];
      wait_cyc(4);
      scl_in = 0;
      meas_irq(400, n);
      chk($sformatf("R7 low delay R=%0d", rl[k]), n, 258 - rl[k]);
      scl_in = 1; wait_cyc(6);
      chk("R8 irq sticky after SCL high", low_irq, 1);
      low_clr = 1; @(posedge clk); #1;
      chk("R8 cleared by pulse", low_irq, 0);
      @(negedge clk); low_clr = 0;
    end

    // R8: set wins over clear in same cycle (R=FF overflows every tick while low)
    low_reload = 8'hFF; scl_in = 0; wait_cyc(6);
    low_clr = 1; @(posedge clk); #1;
    chk("R8 set beats clear", low_irq, 1);
    @(negedge clk); low_clr = 0; scl_in = 1;
    wait_cyc(4);
    low_clr = 1; wait_cyc(1); low_clr = 0;
    chk("R8 clear with SCL high", low_irq, 0);

    finish_run();
  end
endmodule